// File: doc/BRIEF.md
# Framed wake-up address correlator

This block sits behind the preamble detector of a duty-cycled wake-up receiver. Once the preamble has been accepted and `start_i` is pulsed, it watches the synchronised envelope input for a run of high separator bits. It then takes the first low level as the start bit of the first address frame. The destination address follows as k back-to-back asynchronous serial frames. Each frame holds one low start bit, eight data bits sent least significant first, and one high stop bit. Each bit lasts a programmable number of clock cycles, and the block samples it near the middle of that period.

Each received byte is compared, as soon as its stop bit is sampled, with the stored byte at the same position. A sticky flag records any difference, so no buffer for the whole address is needed and k may be as large as the `MAX_FRAMES` parameter allows (64 frames give a 512-bit address). The block ends every attempt with a one-cycle `done_o` pulse that carries exactly one outcome: a wake-up request, an address mismatch, a framing error or a wait timeout. The surrounding logic uses that pulse to remove power from the receiver chain. After the pulse the block is idle and ignores the line until the next `start_i`.

Top module: `addr_wake_correlator`

## Requirements
- R1: During reset and while idle, `done_o`, `wake_o`, `mismatch_o`, `frame_err_o` and `timeout_o` are all low. None of them rises except on the single cycle that reports a result.
- R2: After `start_i` is sampled high while idle, a low on `rx_i` is taken as the first start bit only if `rx_i` has been high for at least j×P consecutive clock cycles just before it (j = `sep_len_i`, P = effective bit period). An earlier low restarts the separator count and is not taken as a start bit.
- R3: A frame is 10 bits of P cycles each: a low start bit, data bits d0 (least significant) to d7, then the stop bit. If c0 is the clock edge at which the start-bit low is first seen, bit n (n = 0..7 data, n = 8 stop) is sampled at edge c0 + (n+1)×P + floor(P/2). `bit_period_i` values below 2 behave as 2.
- R4: The address is k = `frames_i` frames, and received byte f is compared with `id_i[8f+7:8f]`. k = 0 behaves as 1 and k above `MAX_FRAMES` as `MAX_FRAMES`. Frames after the first need no separator: the next low after a stop bit is the next start bit.
- R5: When all k bytes equal their stored bytes, `done_o` and `wake_o` are high together for one cycle, starting right after the stop-bit sampling edge of frame k.
- R6: If any byte differs, the result after frame k is `done_o` with `mismatch_o` and no `wake_o`. A difference in an early frame is kept until the last frame is received.
- R7: A stop bit sampled low ends the attempt at once. The result is `done_o` with `frame_err_o`, and later frames are not awaited.
- R8: If no start bit is seen within `WAIT_CYCLES` clock cycles after the edge that took `start_i` (for frame 0) or after the previous stop-bit sampling edge, `done_o` and `timeout_o` rise right after the edge that many cycles later.
- R9: `start_i` is ignored while an attempt is in progress. It changes neither the received bytes nor the outcome.
- R10: A start bit first seen on the very edge at which the wait limit expires wins over the timeout, and reception proceeds.
- R11: Each `done_o` pulse carries exactly one of the four outcome flags. After it the block stays idle, whatever `rx_i` does, until the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin one attempt (preamble accepted) |
| rx_i | input | 1 | Synchronised demodulated line |
| sep_len_i | input | SEP_W | Separator length j in bits |
| frames_i | input | FRAME_W | Address length k in frames |
| bit_period_i | input | PER_W | Bit period P in clock cycles |
| id_i | input | 8×MAX_FRAMES | Stored address, byte f at bits 8f+7:8f |
| done_o | output | 1 | One-cycle end-of-attempt pulse |
| wake_o | output | 1 | Whole address matched |
| mismatch_o | output | 1 | Address received, but not equal |
| frame_err_o | output | 1 | Stop bit sampled low |
| timeout_o | output | 1 | Waited too long for a start bit |

## Verification
The wait timer can expire on the same clock edge at which the next start bit is first seen. The bench provokes this by holding the line high after `start_i` until one edge before the limit and then driving the start-bit low exactly on the limit edge. It expects the frame to be received and a wake-up reported, with no timeout pulse on that edge or on any other. A second overlap places a `start_i` pulse in the middle of a data bit. There the bench expects the outcome and its cycle to be the same as without the pulse.

// File: rtl/wuc_pkg.sv
package wuc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RECV = 2'd2
    } wuc_state_e;

    typedef struct packed {
        logic wake;
        logic miss;
        logic ferr;
        logic tmo;
    } wuc_result_t;

endpackage

// File: rtl/wuc_run_detect.sv
// Counts whole bit periods of continuous high level while enabled.
module wuc_run_detect #(
    parameter int PER_W = 12,
    parameter int SEP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             rx,
    input  logic [PER_W-1:0] per,
    input  logic [SEP_W-1:0] sep_len,
    output logic             sep_ok
);

    localparam logic [SEP_W-1:0] BITS_MAX = '1;

    typedef struct packed {
        logic [PER_W-1:0] sub;
        logic [SEP_W-1:0] bits;
    } run_t;

    run_t run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (clr) begin
            run_d = '0;
        end else if (en) begin
            if (!rx) begin
                run_d = '0;
            end else if (run_q.sub == per - 1'b1) begin
                run_d.sub = '0;
                if (run_q.bits != BITS_MAX) begin
                    run_d.bits = run_q.bits + 1'b1;
                end
            end else begin
                run_d.sub = run_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    assign sep_ok = (run_q.bits >= sep_len);

    // R2: a low while counting leaves the separator unsatisfied
    p_low_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !rx && sep_len != '0) |=> !sep_ok);

endmodule

// File: rtl/wuc_bit_sampler.sv
// Mid-bit strobe generator and LSB-first shift register for one frame.
module wuc_bit_sampler #(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             en,
    input  logic             rx,
    input  logic [PER_W-1:0] per,
    output logic             strobe,
    output logic [3:0]       idx,
    output logic [7:0]       data
);

    localparam int PH_W = PER_W + 1;

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic [3:0]      idx;
        logic [7:0]      sh;
    } smp_t;

    smp_t smp_d, smp_q;
    logic [PH_W-1:0] first_wait;

    assign first_wait = {1'b0, per} + {2'b0, per[PER_W-1:1]} - 1'b1;
    assign strobe     = en && (smp_q.ph == '0);

    always_comb begin
        smp_d = smp_q;
        if (load) begin
            smp_d.ph  = first_wait;
            smp_d.idx = '0;
        end else if (en) begin
            if (smp_q.ph == '0) begin
                smp_d.ph = {1'b0, per} - 1'b1;
                if (smp_q.idx < 4'd8) begin
                    smp_d.sh = {rx, smp_q.sh[7:1]};
                end
                smp_d.idx = smp_q.idx + 1'b1;
            end else begin
                smp_d.ph = smp_q.ph - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign idx  = smp_q.idx;
    assign data = smp_q.sh;

    // R3: the phase counter never exceeds the first-bit wait
    p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $stable(per)) |-> (smp_q.ph <= first_wait));

    // R3: the controller leaves reception by the stop bit
    p_stop_is_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (smp_q.idx <= 4'd8));

endmodule

// File: rtl/addr_wake_correlator.sv
module addr_wake_correlator
    import wuc_pkg::*;
#(
    parameter int MAX_FRAMES  = 8,
    parameter int PER_W       = 12,
    parameter int SEP_W       = 6,
    parameter int WAIT_CYCLES = 2000,
    localparam int FRAME_W    = $clog2(MAX_FRAMES + 1),
    localparam int ID_W       = MAX_FRAMES * 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               rx_i,
    input  logic [SEP_W-1:0]   sep_len_i,
    input  logic [FRAME_W-1:0] frames_i,
    input  logic [PER_W-1:0]   bit_period_i,
    input  logic [ID_W-1:0]    id_i,
    output logic               done_o,
    output logic               wake_o,
    output logic               mismatch_o,
    output logic               frame_err_o,
    output logic               timeout_o
);

    localparam int IDX_W  = (MAX_FRAMES > 1) ? $clog2(MAX_FRAMES) : 1;
    localparam int WAIT_W = $clog2(WAIT_CYCLES + 1);

    typedef struct packed {
        wuc_state_e       state;
        logic [WAIT_W-1:0] wait_cnt;
        logic [IDX_W-1:0]  frame;
        logic              miss;
        logic              done;
        wuc_result_t       res;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [7:0]       id_bytes [MAX_FRAMES];
    logic [PER_W-1:0] per_eff;
    logic [IDX_W-1:0] last_frame;
    logic             sep_ok, sep_ok_eff, detect;
    logic             strobe;
    logic [3:0]       bit_idx;
    logic [7:0]       rx_byte;
    logic             miss_new;

    for (genvar g = 0; g < MAX_FRAMES; g++) begin : g_id_split
        assign id_bytes[g] = id_i[g*8 +: 8];
    end

    assign per_eff = (bit_period_i < PER_W'(2)) ? PER_W'(2) : bit_period_i;

    always_comb begin
        if (frames_i == '0) begin
            last_frame = '0;
        end else if (frames_i > FRAME_W'(MAX_FRAMES)) begin
            last_frame = IDX_W'(MAX_FRAMES - 1);
        end else begin
            last_frame = IDX_W'(frames_i - 1'b1);
        end
    end

    wuc_run_detect #(.PER_W(PER_W), .SEP_W(SEP_W)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctl_q.state == ST_IDLE && start_i),
        .en      (ctl_q.state == ST_WAIT),
        .rx      (rx_i),
        .per     (per_eff),
        .sep_len (sep_len_i),
        .sep_ok  (sep_ok)
    );

    assign sep_ok_eff = sep_ok || (ctl_q.frame != '0);
    assign detect     = (ctl_q.state == ST_WAIT) && !rx_i && sep_ok_eff;

    wuc_bit_sampler #(.PER_W(PER_W)) u_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (detect),
        .en     (ctl_q.state == ST_RECV),
        .rx     (rx_i),
        .per    (per_eff),
        .strobe (strobe),
        .idx    (bit_idx),
        .data   (rx_byte)
    );

    assign miss_new = ctl_q.miss || (rx_byte != id_bytes[ctl_q.frame]);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.res  = '0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.state    = ST_WAIT;
                    ctl_d.wait_cnt = '0;
                    ctl_d.frame    = '0;
                    ctl_d.miss     = 1'b0;
                end
            end
            ST_WAIT: begin
                if (detect) begin
                    ctl_d.state    = ST_RECV;
                    ctl_d.wait_cnt = '0;
                end else if (ctl_q.wait_cnt == WAIT_W'(WAIT_CYCLES - 1)) begin
                    ctl_d.state   = ST_IDLE;
                    ctl_d.done    = 1'b1;
                    ctl_d.res.tmo = 1'b1;
                end else begin
                    ctl_d.wait_cnt = ctl_q.wait_cnt + 1'b1;
                end
            end
            ST_RECV: begin
                if (strobe && bit_idx == 4'd8) begin
                    if (!rx_i) begin
                        ctl_d.state    = ST_IDLE;
                        ctl_d.done     = 1'b1;
                        ctl_d.res.ferr = 1'b1;
                    end else if (ctl_q.frame == last_frame) begin
                        ctl_d.state    = ST_IDLE;
                        ctl_d.done     = 1'b1;
                        ctl_d.miss     = miss_new;
                        ctl_d.res.wake = !miss_new;
                        ctl_d.res.miss = miss_new;
                    end else begin
                        ctl_d.state    = ST_WAIT;
                        ctl_d.wait_cnt = '0;
                        ctl_d.frame    = ctl_q.frame + 1'b1;
                        ctl_d.miss     = miss_new;
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done_o      = ctl_q.done;
    assign wake_o      = ctl_q.res.wake;
    assign mismatch_o  = ctl_q.res.miss;
    assign frame_err_o = ctl_q.res.ferr;
    assign timeout_o   = ctl_q.res.tmo;

    // R11: one outcome per done pulse, and only with done
    p_one_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($countones({wake_o, mismatch_o, frame_err_o, timeout_o}) == 1));

    p_flag_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o || mismatch_o || frame_err_o || timeout_o) |-> done_o);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: a wake-up follows a stop bit read high
    p_wake_high_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(rx_i));

    // R7: a framing error follows a stop bit read low
    p_ferr_low_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |-> !$past(rx_i));

    // R8: a timeout is only raised out of the waiting state
    p_tmo_from_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> ($past(ctl_q.state) == ST_WAIT));

endmodule

// File: tb/addr_wake_correlator_test.sv
module addr_wake_correlator_test;

    localparam int MAXF  = 8;
    localparam int PW    = 12;
    localparam int SW    = 6;
    localparam int WAITC = 2000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          rx = 1'b1;
    logic [SW-1:0] sep_len = '0;
    logic [3:0]    frames = '0;
    logic [PW-1:0] per = '0;
    logic [63:0]   id = '0;
    logic done, wake, miss, ferr, tmo;

    addr_wake_correlator uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .rx_i         (rx),
        .sep_len_i    (sep_len),
        .frames_i     (frames),
        .bit_period_i (per),
        .id_i         (id),
        .done_o       (done),
        .wake_o       (wake),
        .mismatch_o   (miss),
        .frame_err_o  (ferr),
        .timeout_o    (tmo)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         edge_n;
        logic [3:0] flg;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails = 0;
    int   pe = 8;
    bit   chk_on = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [4:0] act, input logic [4:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at edge %0d: actual done/wake/miss/ferr/tmo=%b expected=%b",
                     tag, cyc, act, expv);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Reference schedule compared on every clock
    always @(negedge clk) begin
        if (chk_on) begin
            logic [4:0] act;
            act = {done, wake, miss, ferr, tmo};
            if (exp_q.size() > 0 && exp_q[0].edge_n == cyc) begin
                check(act == {1'b1, exp_q[0].flg}, exp_q[0].tag, act, {1'b1, exp_q[0].flg});
                void'(exp_q.pop_front());
            end else begin
                check(act == 5'b0, "R1 R11 quiet cycle", act, 5'b0);
            end
        end
    end

    task automatic push(input int e, input logic [3:0] f, input string t);
        exp_t x;
        x.edge_n = e;
        x.flg    = f;
        x.tag    = t;
        exp_q.push_back(x);
    endtask

    task automatic drive(input bit v, input int n);
        repeat (n) begin
            @(negedge clk);
            rx = v;
        end
    endtask

    task automatic do_start(output int s);
        @(negedge clk);
        start = 1'b1;
        rx    = 1'b1;
        s     = cyc + 1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic settle();
        while (exp_q.size() > 0) @(negedge clk);
        rx = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    // One frame; the outcome (if any) is scheduled at its stop-sample edge
    task automatic send_frame(input logic [7:0] b, input bit stopv, input bit poke,
                              input logic [3:0] oc, input string tag, output int e);
        int c0;
        @(negedge clk);
        rx = 1'b0;
        c0 = cyc + 1;
        e  = c0 + 9 * pe + pe / 2;
        if (oc != 4'b0) push(e, oc, tag);
        drive(1'b0, pe - 1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rx = b[i];
            if (poke && i == 3) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                drive(b[i], pe - 2);
            end else begin
                drive(b[i], pe - 1);
            end
        end
        @(negedge clk);
        rx = stopv;
        drive(stopv, pe - 1);
    endtask

    task automatic packet(input int p, input int j, input int kcfg, input int nsend,
                          input logic [63:0] idv, input logic [63:0] tx,
                          input int bad_stop, input int poke_frame, input int extra,
                          input string tag);
        int s, kk, e;
        logic mm;
        logic [3:0] oc;
        bit stopv;
        per     = PW'(p);
        sep_len = SW'(j);
        frames  = 4'(kcfg);
        id      = idv;
        pe      = (p < 2) ? 2 : p;
        kk      = (kcfg == 0) ? 1 : ((kcfg > MAXF) ? MAXF : kcfg);
        do_start(s);
        drive(1'b0, pe);
        drive(1'b1, pe);
        drive(1'b0, pe);
        drive(1'b1, j * pe + extra);
        mm = 1'b0;
        for (int f = 0; f < nsend; f++) begin
            stopv = (f != bad_stop);
            mm = mm | (tx[f*8 +: 8] != idv[f*8 +: 8]);
            if (!stopv) oc = 4'b0010;
            else if (f == kk - 1) oc = mm ? 4'b0100 : 4'b1000;
            else oc = 4'b0000;
            send_frame(tx[f*8 +: 8], stopv, f == poke_frame, oc, tag, e);
            if (oc != 4'b0) break;
            if (f == nsend - 1) push(e + WAITC, 4'b0001, tag);
        end
        settle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=complete");
        finish_up();
    end

    initial begin
        int s, e;
        repeat (2) @(negedge clk);
        check({done, wake, miss, ferr, tmo} == 5'b0, "R1 reset outputs",
              {done, wake, miss, ferr, tmo}, 5'b0);
        @(negedge clk);
        rst_n  = 1'b1;
        chk_on = 1'b1;
        repeat (3) @(negedge clk);

        // R5 R3: 24-bit address matches
        packet(8, 3, 3, 3, 64'h96_6955, 64'h96_6955, -1, -1, 3, "R5 R3 match k=3");
        // R11: line activity with no start produces nothing
        send_frame(8'h55, 1'b1, 1'b0, 4'b0, "R11 idle", e);
        settle();
        // R6: last byte differs
        packet(8, 3, 3, 3, 64'h96_6955, 64'h97_6955, -1, -1, 3, "R6 last byte differs");
        // R6: first byte differs, later ones equal (sticky)
        packet(8, 3, 3, 3, 64'h96_6955, 64'h96_6954, -1, -1, 3, "R6 sticky first byte");
        // R7: stop bit low in the second frame
        packet(8, 3, 3, 3, 64'h96_6955, 64'h96_6955, 1, -1, 3, "R7 framing error");
        // R2: exactly j*P high cycles is enough
        packet(8, 3, 2, 2, 64'hC3A5, 64'hC3A5, -1, -1, 0, "R2 exact separator");
        // R9: start pulse mid-frame is ignored
        packet(8, 2, 2, 2, 64'h3C0F, 64'h3C0F, -1, 0, 3, "R9 start ignored");
        // R8: timeout between frames
        packet(8, 3, 3, 1, 64'h96_6955, 64'h96_6955, -1, -1, 3, "R8 inter-frame timeout");
        // R4: full-length address, odd period
        packet(5, 2, 8, 8, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, -1, -1, 1,
               "R4 k=8 match");
        // R4 R3: k=0 acts as one frame, period 1 acts as 2
        packet(1, 2, 0, 1, 64'h00A7, 64'h00A7, -1, -1, 1, "R4 R3 k=0 P=1");

        // R2: one cycle short of the separator, then silence -> timeout
        per = PW'(8); sep_len = SW'(3); frames = 4'd1; id = 64'h5A; pe = 8;
        do_start(s);
        push(s + WAITC, 4'b0001, "R2 short separator rejected");
        drive(1'b0, pe);
        drive(1'b1, 3 * pe - 1);
        drive(1'b0, pe);
        drive(1'b1, 1);
        settle();

        // R8: never any low after start
        do_start(s);
        push(s + WAITC, 4'b0001, "R8 no start bit");
        settle();

        // R10: start bit lands on the timeout edge
        do_start(s);
        drive(1'b1, WAITC - 2);
        send_frame(8'h5A, 1'b1, 1'b0, 4'b1000, "R10 start bit beats timeout", e);
        settle();

        finish_up();
    end

endmodule